// File: doc/BRIEF.md
# Serial Flash Write-Protection Gatekeeper

This block decides whether each instruction of a serial NOR flash may go ahead. Opcode decoding happens upstream. The block receives one strobe per decoded instruction, along with the target byte address, the status value to be written, a supply-good level, the active-low write-protect pin and a pulse that marks the end of an internal program, erase or status-write operation. One cycle after each strobe it raises either an accept flag or a reject flag. It also holds the write-enable latch, the power-down state and the protection status bits.

Several guards stand between a request and the array. A supply-good level gates all activity. A power-up lockout counter runs in clock cycles. A write-enable latch must be armed before each modifying operation and disarms itself when that operation finishes. A status-lock bit works together with the write-protect pin. A level/direction pair fences off a power-of-two share of the array at its top or bottom end. A power-down state lets only its release instruction through.

Top module: `flash_wp_gate`

## Requirements
- R1: While `supply_ok` is low, every strobe is rejected and the latch and power-down state are forced to 0. The power-up count restarts and `ready_o` drops. The protection status bits keep their value.
- R2: Each strobe (at most one per cycle) yields exactly one of `acc_o` or `rej_o` for one cycle, at the rising edge that samples it. A cycle with no strobe leaves both low.
- R3: Write enable, page program, all three erases and status write are rejected until `supply_ok` has been sampled high at `PWRUP_CYCLES` earlier rising edges. From that point `ready_o` is 1.
- R4: The write-enable latch (`wr_latch_o`) is 0 after reset and after power-up. An accepted write enable sets it, and an accepted write disable clears it at once.
- R5: Page program, sector erase, block erase, chip erase and status write are rejected while the latch is 0. A rejected request of these kinds leaves the latch unchanged.
- R6: Once such an operation is accepted, further modifying requests and write enable are rejected until `op_done` pulses. That pulse clears the latch.
- R7: A status write loads `sr_wdata` into `status_o` in the cycle it is accepted. The fields are bit 4 = lock, bit 3 = top select and bits 2:0 = protection level. The write is rejected while lock is 1 and `wp_n` is 0.
- R8: Level 0 protects nothing. Level L (1..7) protects 2^ADDR_W >> (7-L) bytes, placed at the highest addresses when top select is 1 and at the lowest when it is 0. A page program, sector erase or block erase whose address falls inside that region is rejected.
- R9: Chip erase is rejected whenever the protection level is nonzero.
- R10: An accepted power-down instruction sets `pdown_o`. While it is set, every strobe except release is rejected and has no effect. Release is accepted and clears `pdown_o`.
- R11: Synchronous `rst` clears all state, including the status bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| supply_ok | input | 1 | Supply above write threshold |
| wp_n | input | 1 | Write-protect pin, active low |
| cmd_wren | input | 1 | Write enable strobe |
| cmd_wrdis | input | 1 | Write disable strobe |
| cmd_prog | input | 1 | Page program strobe |
| cmd_serase | input | 1 | Sector erase strobe |
| cmd_berase | input | 1 | Block erase strobe |
| cmd_cerase | input | 1 | Chip erase strobe |
| cmd_wrsr | input | 1 | Status write strobe |
| cmd_pdown | input | 1 | Power-down strobe |
| cmd_release | input | 1 | Release power-down strobe |
| cmd_addr | input | ADDR_W | Target byte address |
| sr_wdata | input | 5 | Status value for a status write |
| op_done | input | 1 | End of internal operation pulse |
| acc_o | output | 1 | Request accepted |
| rej_o | output | 1 | Request rejected |
| wr_latch_o | output | 1 | Write-enable latch |
| status_o | output | 5 | Lock, top select, level |
| pdown_o | output | 1 | Power-down state |
| ready_o | output | 1 | Power-up lockout elapsed |

## Verification
The hardest case to reach is a modifying request that fails for exactly one reason while every other guard would pass. The latch is armed, no operation is in progress, the supply has settled and the device is not powered down, yet the address lies just inside or just outside the protected region. To get there, the stimulus first programs the status bits through an accepted status write and closes it with an `op_done` pulse. It then arms the latch and issues the request. A table of level, direction and address entries places addresses on both sides of each region edge. The lockout edge gets the same treatment: a write enable is held across the edge where the count is one short and the edge where it completes.

// File: rtl/flash_wp_pkg.sv
package flash_wp_pkg;
  localparam int LVL_W   = 3;
  localparam int LVL_MAX = (1 << LVL_W) - 1;

  typedef enum logic [3:0] {
    CMD_NONE,
    CMD_WREN,
    CMD_WRDIS,
    CMD_PROG,
    CMD_SERASE,
    CMD_BERASE,
    CMD_CERASE,
    CMD_WRSR,
    CMD_PDOWN,
    CMD_RELEASE
  } cmd_e;

  typedef struct packed {
    logic             lock;
    logic             top;
    logic [LVL_W-1:0] lvl;
  } prot_t;

  localparam int PROT_W = $bits(prot_t);
endpackage

// File: rtl/flash_wp_pwrup.sv
module flash_wp_pwrup #(
  parameter int CYCLES = 64
) (
  input  logic clk,
  input  logic rst,
  input  logic supply_ok,
  output logic ready
);
  localparam int CW = $clog2(CYCLES + 1);
  localparam logic [CW-1:0] LIMIT = CW'(CYCLES);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || !supply_ok) begin
      cnt_q <= '0;
    end else if (cnt_q != LIMIT) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign ready = (cnt_q == LIMIT);

  AST_PWRUP_BOUND: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= LIMIT); // R3
  AST_PWRUP_RESTART: assert property (@(posedge clk) disable iff (rst)
    !supply_ok |=> !ready); // R1
endmodule

// File: rtl/flash_wp_cmdsel.sv
module flash_wp_cmdsel
  import flash_wp_pkg::*;
(
  input  logic cmd_wren,
  input  logic cmd_wrdis,
  input  logic cmd_prog,
  input  logic cmd_serase,
  input  logic cmd_berase,
  input  logic cmd_cerase,
  input  logic cmd_wrsr,
  input  logic cmd_pdown,
  input  logic cmd_release,
  output cmd_e cmd,
  output logic is_modify,
  output logic is_ranged
);
  always_comb begin
    if (cmd_release)     cmd = CMD_RELEASE;
    else if (cmd_pdown)  cmd = CMD_PDOWN;
    else if (cmd_wrdis)  cmd = CMD_WRDIS;
    else if (cmd_wren)   cmd = CMD_WREN;
    else if (cmd_wrsr)   cmd = CMD_WRSR;
    else if (cmd_cerase) cmd = CMD_CERASE;
    else if (cmd_berase) cmd = CMD_BERASE;
    else if (cmd_serase) cmd = CMD_SERASE;
    else if (cmd_prog)   cmd = CMD_PROG;
    else                 cmd = CMD_NONE;
  end

  assign is_ranged = (cmd == CMD_PROG) || (cmd == CMD_SERASE) || (cmd == CMD_BERASE);
  assign is_modify = is_ranged || (cmd == CMD_CERASE) || (cmd == CMD_WRSR);
endmodule

// File: rtl/flash_wp_region.sv
module flash_wp_region
  import flash_wp_pkg::*;
#(
  parameter int ADDR_W = 24
) (
  input  logic [ADDR_W-1:0] addr,
  input  prot_t             cfg,
  output logic              hit
);
  logic [LVL_W-1:0]  shift;
  logic [ADDR_W-1:0] hi_mask;
  logic [ADDR_W-1:0] hi_bits;

  always_comb begin
    shift   = ~cfg.lvl;
    hi_mask = ~({ADDR_W{1'b1}} >> shift);
    hi_bits = addr & hi_mask;
    if (cfg.lvl == '0) begin
      hit = 1'b0;
    end else if (cfg.top) begin
      hit = (hi_bits == hi_mask);
    end else begin
      hit = (hi_bits == '0);
    end
  end
endmodule

// File: rtl/flash_wp_gate.sv
module flash_wp_gate
  import flash_wp_pkg::*;
#(
  parameter int ADDR_W       = 24,
  parameter int PWRUP_CYCLES = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              supply_ok,
  input  logic              wp_n,
  input  logic              cmd_wren,
  input  logic              cmd_wrdis,
  input  logic              cmd_prog,
  input  logic              cmd_serase,
  input  logic              cmd_berase,
  input  logic              cmd_cerase,
  input  logic              cmd_wrsr,
  input  logic              cmd_pdown,
  input  logic              cmd_release,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [4:0]        sr_wdata,
  input  logic              op_done,
  output logic              acc_o,
  output logic              rej_o,
  output logic              wr_latch_o,
  output logic [4:0]        status_o,
  output logic              pdown_o,
  output logic              ready_o
);
  cmd_e  cmd_c;
  logic  is_mod_c;
  logic  is_rng_c;
  logic  ready_c;
  logic  hit_c;
  logic  acc_c;
  prot_t prot_q;
  prot_t prot_in;
  logic  latch_q;
  logic  busy_q;
  logic  pdown_q;
  logic  acc_q;
  logic  rej_q;

  assign prot_in = prot_t'(sr_wdata);

  flash_wp_cmdsel u_sel (
    .cmd_wren   (cmd_wren),
    .cmd_wrdis  (cmd_wrdis),
    .cmd_prog   (cmd_prog),
    .cmd_serase (cmd_serase),
    .cmd_berase (cmd_berase),
    .cmd_cerase (cmd_cerase),
    .cmd_wrsr   (cmd_wrsr),
    .cmd_pdown  (cmd_pdown),
    .cmd_release(cmd_release),
    .cmd        (cmd_c),
    .is_modify  (is_mod_c),
    .is_ranged  (is_rng_c)
  );

  flash_wp_pwrup #(.CYCLES(PWRUP_CYCLES)) u_pwrup (
    .clk      (clk),
    .rst      (rst),
    .supply_ok(supply_ok),
    .ready    (ready_c)
  );

  flash_wp_region #(.ADDR_W(ADDR_W)) u_region (
    .addr(cmd_addr),
    .cfg (prot_q),
    .hit (hit_c)
  );

  // Verdict for the strobe present this cycle (supply handled in the register stage)
  always_comb begin
    acc_c = 1'b0;
    case (cmd_c)
      CMD_WREN:    acc_c = ready_c && !pdown_q && !busy_q;
      CMD_WRDIS:   acc_c = !pdown_q;
      CMD_PROG,
      CMD_SERASE,
      CMD_BERASE:  acc_c = ready_c && !pdown_q && latch_q && !busy_q && !hit_c;
      CMD_CERASE:  acc_c = ready_c && !pdown_q && latch_q && !busy_q && (prot_q.lvl == '0);
      CMD_WRSR:    acc_c = ready_c && !pdown_q && latch_q && !busy_q && !(prot_q.lock && !wp_n);
      CMD_PDOWN:   acc_c = !pdown_q;
      CMD_RELEASE: acc_c = 1'b1;
      default:     acc_c = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q   <= 1'b0;
      rej_q   <= 1'b0;
      latch_q <= 1'b0;
      busy_q  <= 1'b0;
      pdown_q <= 1'b0;
      prot_q  <= '0;
    end else if (!supply_ok) begin
      acc_q   <= 1'b0;
      rej_q   <= (cmd_c != CMD_NONE);
      latch_q <= 1'b0;
      busy_q  <= 1'b0;
      pdown_q <= 1'b0;
    end else begin
      acc_q <= acc_c;
      rej_q <= (cmd_c != CMD_NONE) && !acc_c;
      if (op_done && busy_q) begin
        busy_q  <= 1'b0;
        latch_q <= 1'b0;
      end
      if (acc_c) begin
        case (cmd_c)
          CMD_WREN:    latch_q <= 1'b1;
          CMD_WRDIS:   latch_q <= 1'b0;
          CMD_WRSR: begin
            prot_q <= prot_in;
            busy_q <= 1'b1;
          end
          CMD_PROG,
          CMD_SERASE,
          CMD_BERASE,
          CMD_CERASE:  busy_q  <= 1'b1;
          CMD_PDOWN:   pdown_q <= 1'b1;
          CMD_RELEASE: pdown_q <= 1'b0;
          default: ;
        endcase
      end
    end
  end

  assign acc_o      = acc_q;
  assign rej_o      = rej_q;
  assign wr_latch_o = latch_q;
  assign status_o   = prot_q;
  assign pdown_o    = pdown_q;
  assign ready_o    = ready_c;

  AST_OFF_NO_ACCEPT: assert property (@(posedge clk) disable iff (rst)
    !supply_ok |=> (!acc_q && !latch_q && !pdown_q)); // R1
  AST_ONE_VERDICT: assert property (@(posedge clk) disable iff (rst)
    (cmd_c != CMD_NONE) |=> (acc_q ^ rej_q)); // R2
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    (cmd_c == CMD_NONE) |=> (!acc_q && !rej_q)); // R2
  AST_EARLY_WRITE: assert property (@(posedge clk) disable iff (rst)
    (!ready_c && (is_mod_c || cmd_c == CMD_WREN)) |=> !acc_q); // R3
  AST_NEED_LATCH: assert property (@(posedge clk) disable iff (rst)
    (is_mod_c && !latch_q) |=> !acc_q); // R5
  AST_DONE_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (op_done && busy_q && cmd_c != CMD_WREN) |=> !latch_q); // R6
  AST_LOCKED_SR: assert property (@(posedge clk) disable iff (rst)
    (cmd_c == CMD_WRSR && prot_q.lock && !wp_n) |=> (!acc_q && $stable(prot_q))); // R7
  AST_REGION_BLOCK: assert property (@(posedge clk) disable iff (rst)
    (is_rng_c && hit_c) |=> !acc_q); // R8
  AST_CHIP_BLOCK: assert property (@(posedge clk) disable iff (rst)
    (cmd_c == CMD_CERASE && prot_q.lvl != '0) |=> !acc_q); // R9
  AST_PDOWN_IGNORE: assert property (@(posedge clk) disable iff (rst)
    (pdown_q && cmd_c != CMD_RELEASE) |=> !acc_q); // R10
  AST_RESET_CLEAR: assert property (@(posedge clk)
    rst |=> (prot_q == '0 && !latch_q && !pdown_q)); // R11
endmodule

// File: tb/tb_flash_wp_gate.sv
`timescale 1ns/1ps
module tb_flash_wp_gate;
  localparam int AW = 24;
  localparam int P  = 64;
  localparam int NT = 12;
  // entry: [27] top select, [26:24] level, [23:0] address
  localparam logic [27:0] RTAB [NT] = '{
    {1'b0, 3'd1, 24'h03FFFF},
    {1'b0, 3'd1, 24'h040000},
    {1'b1, 3'd1, 24'hFC0000},
    {1'b1, 3'd1, 24'hFBFFFF},
    {1'b0, 3'd0, 24'h000000},
    {1'b1, 3'd4, 24'hE00000},
    {1'b1, 3'd4, 24'hDFFFFF},
    {1'b0, 3'd6, 24'h7FFFFF},
    {1'b0, 3'd6, 24'h800000},
    {1'b1, 3'd7, 24'h000000},
    {1'b0, 3'd7, 24'hFFFFFF},
    {1'b1, 3'd3, 24'h123456}
  };
  localparam int C_WREN = 0, C_WRDIS = 1, C_PROG = 2, C_SER = 3, C_BER = 4,
                 C_CER = 5, C_WRSR = 6, C_PDN = 7, C_REL = 8;

  logic clk = 1'b0;
  logic rst, supply_ok, wp_n, op_done;
  logic [8:0] strb;
  logic [AW-1:0] addr;
  logic [4:0] wdata;
  logic acc_o, rej_o, wr_latch_o, pdown_o, ready_o;
  logic [4:0] status_o;
  int n_chk = 0;
  int n_err = 0;

  always #2 clk = ~clk;

  flash_wp_gate #(.ADDR_W(AW), .PWRUP_CYCLES(P)) dut (
    .clk(clk), .rst(rst), .supply_ok(supply_ok), .wp_n(wp_n),
    .cmd_wren(strb[C_WREN]), .cmd_wrdis(strb[C_WRDIS]), .cmd_prog(strb[C_PROG]),
    .cmd_serase(strb[C_SER]), .cmd_berase(strb[C_BER]), .cmd_cerase(strb[C_CER]),
    .cmd_wrsr(strb[C_WRSR]), .cmd_pdown(strb[C_PDN]), .cmd_release(strb[C_REL]),
    .cmd_addr(addr), .sr_wdata(wdata), .op_done(op_done),
    .acc_o(acc_o), .rej_o(rej_o), .wr_latch_o(wr_latch_o), .status_o(status_o),
    .pdown_o(pdown_o), .ready_o(ready_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic issue(input int c, input logic [AW-1:0] a, input logic [4:0] d,
                       output logic ac, output logic rj);
    @(negedge clk);
    strb  = 9'd1 << c;
    addr  = a;
    wdata = d;
    @(negedge clk);
    ac   = acc_o;
    rj   = rej_o;
    strb = '0;
  endtask

  task automatic done_pulse();
    @(negedge clk);
    op_done = 1'b1;
    @(negedge clk);
    op_done = 1'b0;
  endtask

  task automatic set_prot(input logic [4:0] d);
    logic ac, rj;
    issue(C_WREN, '0, '0, ac, rj);
    issue(C_WRSR, '0, d, ac, rj);
    chk("R7 status write accepted", ac, 1'b1);
    done_pulse();
  endtask

  function automatic logic in_region(input logic top, input logic [2:0] lvl, input logic [AW-1:0] a);
    longint full, sz;
    full = longint'(1) << AW;
    sz   = (lvl == 3'd0) ? 0 : (full >> (7 - int'(lvl)));
    if (top) return longint'(a) >= (full - sz);
    return longint'(a) < sz;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    logic ac, rj;
    rst = 1'b1; supply_ok = 1'b0; wp_n = 1'b1; op_done = 1'b0;
    strb = '0; addr = '0; wdata = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R11 reset state, R2 idle quiet
    chk("R11 latch after reset", wr_latch_o, 1'b0);
    chk("R11 status after reset", status_o, 5'd0);
    chk("R11 pdown after reset", pdown_o, 1'b0);
    chk("R2 idle no accept", acc_o, 1'b0);
    chk("R2 idle no reject", rej_o, 1'b0);

    // R1 supply low rejects
    issue(C_WREN, '0, '0, ac, rj);
    chk("R1 accept while supply low", ac, 1'b0);
    chk("R1 reject while supply low", rj, 1'b1);
    issue(C_REL, '0, '0, ac, rj);
    chk("R1 release while supply low", rj, 1'b1);

    // R3 power-up lockout edge
    @(negedge clk);
    supply_ok = 1'b1;
    repeat (P - 1) @(posedge clk);
    @(negedge clk);
    chk("R3 ready one short", ready_o, 1'b0);
    chk("R4 latch after power-up", wr_latch_o, 1'b0);
    strb = 9'd1 << C_WREN;
    @(negedge clk);
    chk("R3 wren at count-1 rejected", rej_o, 1'b1);
    chk("R3 wren at count-1 not accepted", acc_o, 1'b0);
    @(negedge clk);
    chk("R3 wren at count accepted", acc_o, 1'b1);
    chk("R3 ready at count", ready_o, 1'b1);
    chk("R4 latch set by wren", wr_latch_o, 1'b1);
    strb = '0;
    @(negedge clk);
    chk("R2 single-cycle accept", acc_o, 1'b0);

    // R4 write disable, R5 latch required
    issue(C_WRDIS, '0, '0, ac, rj);
    chk("R4 wrdis accepted", ac, 1'b1);
    chk("R4 latch cleared by wrdis", wr_latch_o, 1'b0);
    issue(C_PROG, 24'h000100, '0, ac, rj);
    chk("R5 program without latch rejected", rj, 1'b1);
    chk("R5 latch stays 0", wr_latch_o, 1'b0);
    issue(C_WRSR, '0, 5'h07, ac, rj);
    chk("R5 status write without latch rejected", rj, 1'b1);
    chk("R5 status unchanged", status_o, 5'd0);

    // R6 busy and auto clear
    issue(C_WREN, '0, '0, ac, rj);
    issue(C_PROG, 24'h000200, '0, ac, rj);
    chk("R6 program accepted", ac, 1'b1);
    chk("R6 latch held while busy", wr_latch_o, 1'b1);
    issue(C_SER, 24'h001000, '0, ac, rj);
    chk("R6 erase while busy rejected", rj, 1'b1);
    issue(C_WREN, '0, '0, ac, rj);
    chk("R6 wren while busy rejected", rj, 1'b1);
    done_pulse();
    chk("R6 latch cleared by done", wr_latch_o, 1'b0);

    // R7 status lock with pin
    set_prot(5'b10000);
    chk("R7 status loaded", status_o, 5'b10000);
    chk("R6 latch cleared after status write", wr_latch_o, 1'b0);
    wp_n = 1'b0;
    issue(C_WREN, '0, '0, ac, rj);
    issue(C_WRSR, '0, 5'b00000, ac, rj);
    chk("R7 locked status write rejected", rj, 1'b1);
    chk("R7 status kept", status_o, 5'b10000);
    chk("R5 latch kept after reject", wr_latch_o, 1'b1);
    wp_n = 1'b1;
    issue(C_WRSR, '0, 5'b00000, ac, rj);
    chk("R7 lock with pin high accepted", ac, 1'b1);
    chk("R7 status cleared", status_o, 5'd0);
    done_pulse();

    // R8 region table
    for (int i = 0; i < NT; i++) begin
      logic exp_acc;
      int   c;
      set_prot({1'b0, RTAB[i][27], RTAB[i][26:24]});
      c = (i % 3 == 0) ? C_PROG : ((i % 3 == 1) ? C_SER : C_BER);
      exp_acc = !in_region(RTAB[i][27], RTAB[i][26:24], RTAB[i][23:0]);
      issue(C_WREN, '0, '0, ac, rj);
      issue(c, RTAB[i][23:0], '0, ac, rj);
      chk($sformatf("R8 entry %0d", i), ac, exp_acc);
      if (exp_acc) begin
        done_pulse();
      end else begin
        chk($sformatf("R5 latch kept entry %0d", i), wr_latch_o, 1'b1);
        issue(C_WRDIS, '0, '0, ac, rj);
      end
    end

    // R9 chip erase
    set_prot(5'b00000);
    issue(C_WREN, '0, '0, ac, rj);
    issue(C_CER, '0, '0, ac, rj);
    chk("R9 chip erase unprotected accepted", ac, 1'b1);
    done_pulse();
    set_prot(5'b01010);
    issue(C_WREN, '0, '0, ac, rj);
    issue(C_CER, '0, '0, ac, rj);
    chk("R9 chip erase protected rejected", rj, 1'b1);
    issue(C_WRDIS, '0, '0, ac, rj);

    // R10 power-down
    issue(C_PDN, '0, '0, ac, rj);
    chk("R10 power-down accepted", ac, 1'b1);
    chk("R10 pdown set", pdown_o, 1'b1);
    issue(C_WREN, '0, '0, ac, rj);
    chk("R10 wren ignored", rj, 1'b1);
    chk("R10 latch untouched", wr_latch_o, 1'b0);
    issue(C_PDN, '0, '0, ac, rj);
    chk("R10 repeat power-down ignored", rj, 1'b1);
    issue(C_REL, '0, '0, ac, rj);
    chk("R10 release accepted", ac, 1'b1);
    chk("R10 pdown cleared", pdown_o, 1'b0);
    issue(C_WREN, '0, '0, ac, rj);
    chk("R10 wren after release", ac, 1'b1);

    // R1 supply drop keeps status
    issue(C_PDN, '0, '0, ac, rj);
    @(negedge clk);
    supply_ok = 1'b0;
    @(negedge clk);
    chk("R1 latch cleared on drop", wr_latch_o, 1'b0);
    chk("R1 pdown cleared on drop", pdown_o, 1'b0);
    chk("R1 ready dropped", ready_o, 1'b0);
    chk("R1 status retained", status_o, 5'b01010);

    // R11 reset clears status
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk("R11 status cleared by reset", status_o, 5'd0);

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule